// File: doc/BRIEF.md
# Bus Wakeup Detector and Flag

This block sits beside a single-wire bus transceiver. It watches the digitised bus level, where 1 means dominant, and a microsecond tick. From these it decides whether a remote node has woken this one. A dominant phase that lasts long enough, and that returns to recessive while the transceiver is in its wakeup sub-mode, raises a one-cycle event. The same condition sets a latched flag.

The flag holds until the mode sequencer issues a clear. The sequencer does this when the host requests normal operation. The block also drives the receive-data output for every transceiver sub-mode:
- In active sub-mode the output follows the bus.
- In wakeup sub-mode the output shows the pending flag as a low level.
- In off sub-mode the output is held high.

Duration counting carries across a change from active to wakeup sub-mode. A wakeup pattern that starts while the transceiver is still transmitting therefore counts as valid.

Top module: `bus_wakeup_detector`

## Requirements
- R1: While the sub-mode is wakeup (code 01) or active (code 10) and the bus is dominant, each tick adds one to the dominant duration. A phase qualifies once WAKE_US ticks have been counted.
- R2: A dominant phase with fewer than WAKE_US ticks raises no event and leaves the flag unchanged.
- R3: A qualifying phase raises wake_evt_o for exactly one cycle. This happens on the clock edge where the bus is seen recessive after dominant, and only if the sub-mode is wakeup at that edge.
- R4: A dominant phase that begins in active sub-mode and is released in wakeup sub-mode is judged on its whole duration, including the ticks counted in active.
- R5: The flag rises on the same edge as the event and stays set until clr_i is asserted.
- R6: When clr_i coincides with a new event, the clear wins: the flag ends the cycle at 0 while the event pulse is still reported.
- R7: In wakeup sub-mode, rxd_o is the inverse of the flag.
- R8: In active sub-mode, rxd_o is low while the bus is dominant and high while it is recessive, whatever the flag.
- R9: In off sub-mode (code 00, and the unused code 11 treated the same), no ticks are counted, no event is raised and rxd_o is high.
- R10: The duration counter saturates at WAKE_US. A dominant phase longer than the counter's wrap length still yields exactly one event.
- R11: A qualifying phase that is released in active sub-mode raises no event.
- R12: After reset, wake_evt_o and wake_flag_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle microsecond strobe |
| bus_dom_i | input | 1 | Digitised bus level, 1 = dominant |
| sub_mode_i | input | 2 | Transceiver sub-mode: 00 off, 01 wakeup, 10 active, 11 off |
| clr_i | input | 1 | Flag clear from the mode sequencer |
| wake_evt_o | output | 1 | One-cycle valid wakeup pulse |
| wake_flag_o | output | 1 | Latched pending wakeup |
| rxd_o | output | 1 | Receive-data output |

## Verification
The hardest case to reach is a dominant phase that changes sub-mode partway through. It must be scored on its combined length, or on only its later part when it began in off. The bench sweeps every start and end sub-mode code against every duration from zero to past the threshold. It switches the sub-mode at the midpoint of each phase and predicts the outcome from the ticks counted in live modes. A duration well past the counter's wrap length shows that saturation works. A release edge that coincides with a clear shows the priority.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
  typedef logic [1:0] sub_mode_t;
  localparam sub_mode_t MODE_OFF    = 2'b00;
  localparam sub_mode_t MODE_WAKE   = 2'b01;
  localparam sub_mode_t MODE_ACTIVE = 2'b10;
endpackage

// File: rtl/wkd_dom_timer.sv
module wkd_dom_timer
  import wkd_pkg::*;
#(
  parameter int WAKE_US = 80,
  localparam int CNT_W = $clog2(WAKE_US + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      dom_i,
  input  sub_mode_t mode_i,
  output logic      hit_o,
  output logic      evt_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAKE_US);

  logic [CNT_W-1:0] cnt_q;
  logic dom_q, live, qual;

  always_comb begin
    live  = (mode_i == MODE_WAKE) || (mode_i == MODE_ACTIVE);
    qual  = (cnt_q == LIMIT);
    hit_o = dom_q && !dom_i && qual && (mode_i == MODE_WAKE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dom_q <= 1'b0;
      evt_o <= 1'b0;
    end else begin
      // counter survives active->wakeup changes; saturates at LIMIT
      if (!live || !dom_i) cnt_q <= '0;
      else if (tick_i && !qual) cnt_q <= cnt_q + 1'b1;
      dom_q <= dom_i && live;
      evt_o <= hit_o;
    end
  end

  assert_cnt_saturates_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_evt_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  assert_evt_needs_wake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $past(mode_i == MODE_WAKE));
  assert_off_no_evt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |=> !evt_o);
endmodule

// File: rtl/wkd_flag.sv
module wkd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
  end

  assert_clr_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> !flag_o);
  assert_flag_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_flag_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/wkd_rxd_sel.sv
module wkd_rxd_sel
  import wkd_pkg::*;
(
  input  sub_mode_t mode_i,
  input  logic      dom_i,
  input  logic      flag_i,
  output logic      rxd_o
);
  always_comb begin
    unique case (mode_i)
      MODE_ACTIVE: rxd_o = !dom_i;
      MODE_WAKE:   rxd_o = !flag_i;
      default:     rxd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bus_wakeup_detector.sv
module bus_wakeup_detector
  import wkd_pkg::*;
#(
  parameter int WAKE_US = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_us_i,
  input  logic       bus_dom_i,
  input  logic [1:0] sub_mode_i,
  input  logic       clr_i,
  output logic       wake_evt_o,
  output logic       wake_flag_o,
  output logic       rxd_o
);
  logic hit;

  wkd_dom_timer #(.WAKE_US(WAKE_US)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_us_i),
    .dom_i  (bus_dom_i),
    .mode_i (sub_mode_i),
    .hit_o  (hit),
    .evt_o  (wake_evt_o)
  );

  wkd_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_i),
    .flag_o (wake_flag_o)
  );

  wkd_rxd_sel u_rxd (
    .mode_i (sub_mode_i),
    .dom_i  (bus_dom_i),
    .flag_i (wake_flag_o),
    .rxd_o  (rxd_o)
  );

  assert_flag_with_evt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_flag_o) |-> wake_evt_o);
endmodule

// File: tb/bus_wakeup_detector_bench.sv
module bus_wakeup_detector_bench;
  localparam int TH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, dom = 1'b0, clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic evt, flag, rxd;
  int n_chk = 0, n_bad = 0;
  logic flag_exp = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_wakeup_detector #(.WAKE_US(TH)) u_bus_wakeup_detector (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .bus_dom_i(dom),
    .sub_mode_i(mode), .clr_i(clr), .wake_evt_o(evt), .wake_flag_o(flag), .rxd_o(rxd)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
      tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  function automatic bit is_live(input int m);
    return (m == 1) || (m == 2);
  endfunction

  task automatic pulse(input int d, input int m0, input int m1);
    int h, total;
    logic evt_exp, rx_exp;
    h = d / 2;
    @(negedge clk) begin mode = 2'(m0); dom = 1'b1; end
    ticks(h);
    @(negedge clk) mode = 2'(m1);
    ticks(d - h);
    if (d == 0) repeat (2) @(negedge clk);
    total = is_live(m1) ? ((is_live(m0) ? h : 0) + (d - h)) : 0;
    // R8/R7/R9 while still dominant
    rx_exp = (m1 == 2) ? 1'b0 : (m1 == 1) ? !flag_exp : 1'b1;
    chk("R8 R7 R9 rxd during dominant", rxd, rx_exp);
    dom = 1'b0;
    evt_exp = (m1 == 1) && (total >= TH);  // R1 R2 R4 R10 R11
    if (evt_exp) flag_exp = 1'b1;
    @(negedge clk);
    chk("R1 R2 R3 R4 R11 event", evt, evt_exp);
    chk("R5 R2 flag after release", flag, flag_exp);
    rx_exp = (m1 == 1) ? !flag_exp : 1'b1;
    chk("R7 R8 R9 rxd after release", rxd, rx_exp);
    @(negedge clk);
    chk("R3 single pulse", evt, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5 flag held", flag, flag_exp);
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    flag_exp = 1'b0;
    chk("R5 flag cleared", flag, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 evt in reset", evt, 1'b0);
    chk("R12 flag in reset", flag, 1'b0);
    chk("R9 rxd in reset", rxd, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 flag after reset", flag, 1'b0);
    for (int m0 = 0; m0 < 4; m0++)
      for (int m1 = 0; m1 < 4; m1++) begin
        for (int d = 0; d <= TH + 3; d++) pulse(d, m0, m1);
        pulse(20, m0, m1);  // R10: beyond the 3-bit wrap
      end
    // R6: clear coincides with the release that qualifies
    @(negedge clk) begin mode = 2'b01; dom = 1'b1; end
    ticks(TH);
    @(negedge clk) begin dom = 1'b0; clr = 1'b1; end
    @(negedge clk) clr = 1'b0;
    chk("R6 event still reported", evt, 1'b1);
    chk("R6 clear wins", flag, 1'b0);
    chk("R6 R7 rxd high", rxd, 1'b1);
    // R8: active ignores a pending flag
    @(negedge clk) begin mode = 2'b01; dom = 1'b1; end
    ticks(TH + 1);
    @(negedge clk) dom = 1'b0;
    @(negedge clk) mode = 2'b10;
    @(negedge clk);
    chk("R5 flag set", flag, 1'b1);
    chk("R8 rxd recessive with flag", rxd, 1'b1);
    dom = 1'b1;
    #1 chk("R8 rxd dominant", rxd, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule